// File: doc/BRIEF.md
# Playback Seconds Counter

This block keeps the elapsed playback time of an audio decoder in whole seconds. Each output sample produced by the decoder arrives as a one-cycle tick. While the decoder flags its data as valid, these ticks feed a sub-second accumulator. The accumulator is compared against a programmable sample rate in Hz. Each time the accumulator completes a full second, it restarts from zero and the 16-bit seconds register steps up by one.

A host can overwrite the seconds value through a simple write port. A single write is never trusted. The new value is adopted only when two successive writes carry the same word. This filters out a torn or spurious host access. Adopting a host value also restarts the sub-second accumulator, so the first increment after the overwrite comes one full second later.

A software-reset pulse from the decoder clears the time, the accumulator and any half-finished write pair. The synchronous active-low hardware reset clears the same three pieces of state.

Top module: `play_time_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `time_q` reads 0 after that edge, and the accumulator and the pending write are also cleared.
- R2: A qualified tick is a cycle with `sample_tick` and `dec_valid` both high. A qualified tick that brings the accumulator count up to `rate_hz` resets the accumulator to 0, and `time_q` rises by one after that edge. A `rate_hz` of 0 or 1 therefore gives one increment per qualified tick.
- R3: A `sample_tick` that arrives while `dec_valid` is low changes neither `time_q` nor the accumulator.
- R4: An increment from 0xFFFF gives 0x0000. The counter wraps; it does not saturate.
- R5: `soft_rst` high at an edge clears `time_q`, the accumulator and the pending write. It overrides a tick and a write in the same cycle.
- R6: A write whose `wr_data` equals the data of the write just before it (with no reset in between) commits. `time_q` equals that data after the same edge.
- R7: A lone write, or a write whose data differs from the write before it, leaves `time_q` unchanged. The differing write is kept as the first half of a new pair.
- R8: A commit resets the accumulator to 0 and discards a qualified tick in the same cycle. The next increment needs `rate_hz` further qualified ticks.
- R9: A commit consumes the pair. A third identical write after a commit counts as a first write and does not commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sample_tick | input | 1 | One pulse per decoded output sample |
| dec_valid | input | 1 | Decoder is processing correct data |
| soft_rst | input | 1 | Software-reset pulse from the decoder |
| rate_hz | input | RATE_W (20) | Samples per second |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | TIME_W (16) | Host write data |
| time_q | output | TIME_W (16) | Elapsed seconds |

## Verification
Two pairs of events can land in the same cycle.

- The second write of a matching pair can coincide with the qualified tick that would complete a second. The load must win, and the accumulator must restart so that the next step comes `rate_hz` ticks later.
- A software reset can coincide with a completing write pair. The reset must win, and it must also drop the half-pair state.

Directed sequences place these events on the same edge on purpose. The random phase, with small rates and frequent writes, produces many more such collisions. A cycle-level reference model in the bench judges every cycle.

// File: rtl/pt_pkg.sv
// Shared types for the playback seconds counter.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package pt_pkg;

    // State of the double-write filter: waiting for a first write, or
    // holding a first write and waiting for its twin.
    typedef enum logic {
        PAIR_EMPTY = 1'b0,
        PAIR_ARMED = 1'b1
    } pair_state_t;

endpackage

// File: rtl/pt_sample_accum.sv
// Sub-second sample accumulator.
// Counts qualified ticks (tick with valid) and emits a one-cycle pulse on the
// tick that completes a second, i.e. when the count reaches rate.
// Assumes rate may change at any time; a count already at or beyond a new
// lower rate completes on the next qualified tick.
module pt_sample_accum #(
    parameter int RATE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              valid,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic              sec_pulse
);
    localparam int EXT_W = RATE_W + 1;

    logic [RATE_W-1:0] acc_q;
    logic [EXT_W-1:0]  acc_inc;
    logic              qualified;
    logic              reached;

    // Widened increment so the compare never overflows.
    always_comb begin
        acc_inc   = {1'b0, acc_q} + EXT_W'(1);
        qualified = tick && valid;
        reached   = acc_inc >= {1'b0, rate};
        sec_pulse = qualified && reached && !clear;
    end

    // Accumulator register: clear wins, else count or wrap on qualified tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (qualified) begin
            acc_q <= reached ? '0 : acc_inc[RATE_W-1:0];
        end
    end

endmodule

// File: rtl/pt_write_pair.sv
// Double-write filter for host overwrites.
// A write commits only when its data equals the previous write's data.
// A differing write becomes the first half of a new pair; a commit empties
// the filter. Flush (software reset) empties it and blocks a commit.
module pt_write_pair #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              commit,
    output logic [DATA_W-1:0] commit_val
);
    import pt_pkg::*;

    pair_state_t       state_q;
    logic [DATA_W-1:0] held_q;

    // Commit when armed and the new word matches the held one.
    always_comb begin
        commit     = wr_en && !flush && (state_q == PAIR_ARMED) && (wr_data == held_q);
        commit_val = held_q;
    end

    // Pair state and held word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PAIR_EMPTY;
            held_q  <= '0;
        end else if (flush) begin
            state_q <= PAIR_EMPTY;
        end else if (wr_en) begin
            if (commit) begin
                state_q <= PAIR_EMPTY;
            end else begin
                state_q <= PAIR_ARMED;
                held_q  <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pt_sec_count.sv
// Seconds register with priority clear > load > increment.
// Increments wrap modulo 2**TIME_W.
module pt_sec_count #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    input  logic              inc,
    output logic [TIME_W-1:0] count
);
    logic [TIME_W-1:0] cnt_q;

    // Seconds register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (inc) begin
            cnt_q <= cnt_q + TIME_W'(1);
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/play_time_counter.sv
// Playback seconds counter top.
// Ties the sample accumulator, the double-write filter and the seconds
// register together. Software reset clears all three; a committed host
// write loads the seconds and restarts the accumulator.
// Assumes sample_tick is a single-cycle pulse per decoded sample.
module play_time_counter #(
    parameter int TIME_W = 16,
    parameter int RATE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              dec_valid,
    input  logic              soft_rst,
    input  logic [RATE_W-1:0] rate_hz,
    input  logic              wr_en,
    input  logic [TIME_W-1:0] wr_data,
    output logic [TIME_W-1:0] time_q
);
    logic              wp_commit;
    logic [TIME_W-1:0] wp_value;
    logic              acc_sec_pulse;
    logic              acc_clear;

    // Accumulator restarts on software reset or on an adopted host value.
    assign acc_clear = soft_rst || wp_commit;

    pt_write_pair #(.DATA_W(TIME_W)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (soft_rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .commit     (wp_commit),
        .commit_val (wp_value)
    );

    pt_sample_accum #(.RATE_W(RATE_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_tick),
        .valid     (dec_valid),
        .clear     (acc_clear),
        .rate      (rate_hz),
        .sec_pulse (acc_sec_pulse)
    );

    pt_sec_count #(.TIME_W(TIME_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (soft_rst),
        .load     (wp_commit),
        .load_val (wp_value),
        .inc      (acc_sec_pulse),
        .count    (time_q)
    );

endmodule

// File: rtl/play_time_counter_chk.sv
// Property checker for play_time_counter, attached with bind.
module play_time_counter_chk #(
    parameter int TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_tick,
    input logic              dec_valid,
    input logic              soft_rst,
    input logic [TIME_W-1:0] wr_data,
    input logic [TIME_W-1:0] time_q,
    input logic              wp_commit,
    input logic              acc_sec_pulse
);
    // R2 R4
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sec_pulse && !wp_commit && !soft_rst |=> time_q == $past(time_q) + TIME_W'(1));

    // R3
    pulse_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sec_pulse |-> (dec_valid && sample_tick));

    // R5
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> time_q == '0);

    // R6
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_commit |=> time_q == $past(wr_data));

    // R7
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst && !wp_commit && !acc_sec_pulse |=> $stable(time_q));

    // R5 R8
    commit_blocks_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_commit || soft_rst) |-> !acc_sec_pulse);
endmodule

bind play_time_counter play_time_counter_chk #(.TIME_W(TIME_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_tick   (sample_tick),
    .dec_valid     (dec_valid),
    .soft_rst      (soft_rst),
    .wr_data       (wr_data),
    .time_q        (time_q),
    .wp_commit     (wp_commit),
    .acc_sec_pulse (acc_sec_pulse)
);

// File: tb/play_time_counter_test.sv
// Self-checking bench: directed corners plus seeded random stimulus,
// compared each cycle against a reference model kept in bench variables.
module play_time_counter_test;
    localparam int TW = 16;
    localparam int RW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_tick = 1'b0;
    logic          dec_valid = 1'b0;
    logic          soft_rst = 1'b0;
    logic [RW-1:0] rate_hz = '0;
    logic          wr_en = 1'b0;
    logic [TW-1:0] wr_data = '0;
    logic [TW-1:0] time_q;

    int checks = 0;
    int fails = 0;

    // Reference model state.
    logic [TW-1:0] m_time = '0;
    int            m_acc = 0;
    bit            m_pend = 1'b0;
    logic [TW-1:0] m_held = '0;
    string         m_tag = "R1";

    always #10 clk = ~clk; // 50 MHz

    play_time_counter #(.TIME_W(TW), .RATE_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .dec_valid(dec_valid),
        .soft_rst(soft_rst), .rate_hz(rate_hz), .wr_en(wr_en), .wr_data(wr_data),
        .time_q(time_q)
    );

    task automatic check(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: time_q=%h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: next state from current inputs, per the requirements.
    task automatic model_update(input bit hw, input bit tk, input bit vl, input bit sr,
                                input bit we, input logic [TW-1:0] wd);
        bit commit;
        m_tag = "R3";
        if (hw || sr) begin
            m_time = '0; m_acc = 0; m_pend = 1'b0;
            if (hw) m_held = '0;
            m_tag = hw ? "R1" : "R5";
        end else begin
            commit = we && m_pend && (wd == m_held);
            if (commit) begin
                m_time = m_held; m_acc = 0; m_pend = 1'b0; m_tag = "R6";
            end else begin
                if (we) begin m_pend = 1'b1; m_held = wd; m_tag = "R7"; end
                if (tk && vl) begin
                    if (m_acc + 1 >= int'(rate_hz)) begin
                        m_tag = (m_time == '1) ? "R4" : "R2";
                        m_acc = 0; m_time = m_time + TW'(1);
                    end else begin
                        m_acc++;
                    end
                end
            end
        end
    endtask

    // Drive one cycle at the falling edge, then compare at the next falling edge.
    task automatic step(input bit tk, input bit vl, input bit sr, input bit we,
                        input logic [TW-1:0] wd);
        sample_tick = tk; dec_valid = vl; soft_rst = sr; wr_en = we; wr_data = wd;
        model_update(!rst_n, tk, vl, sr, we, wd);
        @(posedge clk);
        @(negedge clk);
        check(m_tag, time_q, m_time);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 1'b0, '0);
    endtask

    task automatic write1(input logic [TW-1:0] v);
        step(1'b0, 1'b0, 1'b0, 1'b1, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        rate_hz = 20'd4;
        step(1'b1, 1'b1, 1'b0, 1'b1, 16'h5555);
        step(1'b0, 1'b0, 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        check("R1", time_q, 16'h0000); // R1 reset state

        // R2: four qualified ticks at rate 4 give one second
        ticks(3);
        check("R2", time_q, 16'h0000);
        ticks(1);
        check("R2", time_q, 16'h0001);

        // R3: ticks without valid are ignored
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0);
        check("R3", time_q, 16'h0001);
        ticks(4);
        check("R3", time_q, 16'h0002);

        // R7: single write, then a mismatched pair, leave the count alone
        write1(16'h1234);
        check("R7", time_q, 16'h0002);
        write1(16'h1111);
        write1(16'h2222);
        check("R7", time_q, 16'h0002);
        // R7 + R6: the differing word became a first half; its twin commits
        write1(16'h2222);
        check("R6", time_q, 16'h2222);

        // R4: load 0xFFFF, then a full second wraps to zero
        write1(16'hFFFF);
        write1(16'hFFFF);
        check("R6", time_q, 16'hFFFF);
        ticks(4);
        check("R4", time_q, 16'h0000);

        // R8: commit in the same cycle as the completing tick
        ticks(3);
        write1(16'h0100);
        step(1'b1, 1'b1, 1'b0, 1'b1, 16'h0100);
        check("R8", time_q, 16'h0100);
        ticks(3);
        check("R8", time_q, 16'h0100);
        ticks(1);
        check("R8", time_q, 16'h0101);

        // R9: third identical write after a commit does not commit
        write1(16'h0100);
        check("R9", time_q, 16'h0101);

        // R5: soft reset colliding with a completing pair wins and drops the pair
        write1(16'h0777);
        step(1'b1, 1'b1, 1'b1, 1'b1, 16'h0777);
        check("R5", time_q, 16'h0000);
        write1(16'h0777);
        check("R5", time_q, 16'h0000);

        // R2: rate 0 and rate 1 step on every qualified tick
        rate_hz = 20'd1;
        ticks(2);
        check("R2", time_q, 16'h0002);
        rate_hz = 20'd0;
        ticks(1);
        check("R2", time_q, 16'h0003);

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            logic [TW-1:0] wd;
            if (i % 500 == 0) rate_hz = RW'($urandom_range(0, 9));
            case ($urandom_range(0, 3))
                0: wd = 16'h0000;
                1: wd = 16'h0001;
                2: wd = 16'hFFFE;
                default: wd = 16'hFFFF;
            endcase
            step(1'($urandom_range(0, 1)), ($urandom_range(0, 9) < 7),
                 ($urandom_range(0, 99) == 0), ($urandom_range(0, 9) < 2), wd);
        end

        // R1: hardware reset mid-run clears the count
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b1, 16'h00AA);
        rst_n = 1'b1;
        check("R1", time_q, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule